// File: doc/BRIEF.md
# Block SAD Disparity Search

This block is a stereo matching engine. It takes matching rows of a left and a right image, already filtered and carried as 16-bit samples, and finds a horizontal disparity for every pixel of each row. The block keeps the most recent rows of each image in a rolling line buffer. Once a row pair is complete, it scores every candidate shift with a block sum of absolute differences (SAD) over a square window and returns the index of the lowest score. Defaults are 320-pixel rows, 30 candidate disparities, a 7-by-7 window and a 16-bit saturating score. The result is a 5-bit disparity from 0 to 29.

Rows arrive one pixel per beat as left/right pairs on a valid/ready stream. The last beat of a row moves the controller from FILL to SEARCH. In SEARCH, one window column is scored per cycle, for all buffered rows at once. After the final candidate of a pixel, the controller moves from SEARCH to EMIT and holds the result until the consumer takes it. It then goes from EMIT back to SEARCH for the next pixel, or from EMIT to FILL after the last pixel of the row. Input is refused in SEARCH and EMIT, so a row is never overwritten while it is being searched.

Top module: `sad_disparity_search`

## Requirements
- R1: While reset is held and just after it, in_ready is 1 and out_valid is 0.
- R2: A row is exactly ROW_LEN accepted beats. From the cycle after the last beat until the last result of that row is accepted, in_ready is 0.
- R3: The score of pixel x at disparity d is the sum of |left[r][c] - right[r][c-d]| over every buffered row r and every column c from x-WIN/2 to x+WIN/2. A term is dropped if c lies outside 0..ROW_LEN-1 or if c-d is negative.
- R4: The score saturates at 65535 (2^SAD_W-1). Each window column is added with clamping, so the score never wraps.
- R5: The reported disparity is the candidate with the lowest score.
- R6: When scores tie, the smaller disparity is reported. For example, identical images or saturated scores give 0.
- R7: A disparity d larger than x is never considered, so out_disp is at most x.
- R8: Each row produces exactly ROW_LEN results, in column order 0 to ROW_LEN-1. Each result is an unsigned value from 0 to NUM_DISP-1. After the last result, in_ready returns to 1.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_disp does not change.
- R10: The buffer holds the most recent WIN row pairs. Before WIN rows have arrived since reset, only the rows received so far contribute to the score.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel pair is valid |
| in_ready | output | 1 | Block accepts an input pixel pair |
| in_left | input | PIX_W | Left-image sample |
| in_right | input | PIX_W | Right-image sample |
| out_valid | output | 1 | Disparity result is valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_disp | output | $clog2(NUM_DISP) | Best disparity index |

## Verification
The sharpest overlap is the cycle that adds the last window column of a candidate. In that same cycle the clamped sum is finished, compared against the best score so far, and the tie rule is applied. This is provoked with identical images, where every candidate scores zero, and with full-scale opposing images, where every candidate saturates. Both cases must report 0, and a wrap or a non-strict compare would show a different index. A second overlap is row completion, where the last write and the marking of the row as valid coincide with the first search cycle that reads that row. This is judged by comparing every result of a freshly filled buffer against a model kept in the bench, including the first rows after reset.

// File: rtl/sad_pkg.sv
package sad_pkg;
    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_EMIT   = 2'd2
    } sad_state_e;
endpackage

// File: rtl/sad_line_buffer.sv
module sad_line_buffer #(
    parameter int ROW_LEN = 320,
    parameter int WIN     = 7,
    parameter int PIX_W   = 16,
    localparam int X_W    = $clog2(ROW_LEN),
    localparam int SLOT_W = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic [X_W-1:0]       wr_col,
    input  logic [PIX_W-1:0]     wr_data,
    input  logic [X_W-1:0]       rd_col,
    output logic [WIN*PIX_W-1:0] rd_bus
);
    logic [PIX_W-1:0] mem [WIN][ROW_LEN];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_slot][wr_col] <= wr_data;
        end
    end

    for (genvar s = 0; s < WIN; s++) begin : g_rd
        assign rd_bus[s*PIX_W +: PIX_W] = mem[s][rd_col];
    end
endmodule

// File: rtl/sad_col_sum.sv
module sad_col_sum #(
    parameter int WIN   = 7,
    parameter int PIX_W = 16,
    localparam int SUM_W = PIX_W + $clog2(WIN + 1)
) (
    input  logic                 en,
    input  logic [WIN-1:0]       row_vld,
    input  logic [WIN*PIX_W-1:0] l_bus,
    input  logic [WIN*PIX_W-1:0] r_bus,
    output logic [SUM_W-1:0]     sum
);
    logic [PIX_W-1:0] diff [WIN];

    for (genvar s = 0; s < WIN; s++) begin : g_diff
        logic [PIX_W-1:0] lv, rv;
        assign lv = l_bus[s*PIX_W +: PIX_W];
        assign rv = r_bus[s*PIX_W +: PIX_W];
        assign diff[s] = (lv > rv) ? (lv - rv) : (rv - lv);
    end

    always_comb begin
        sum = '0;
        for (int s = 0; s < WIN; s++) begin
            if (en && row_vld[s]) begin
                sum = sum + SUM_W'(diff[s]);
            end
        end
    end
endmodule

// File: rtl/sad_min_select.sv
module sad_min_select #(
    parameter int SAD_W  = 16,
    parameter int DISP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              first,
    input  logic [SAD_W-1:0]  cand_sad,
    input  logic [DISP_W-1:0] cand_d,
    output logic [DISP_W-1:0] best_d
);
    logic [SAD_W-1:0] best_sad;
    logic             take;

    // Strict compare keeps the earlier (smaller) disparity on a tie.
    assign take = upd_en && (first || (cand_sad < best_sad));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_sad <= '0;
            best_d   <= '0;
        end else if (take) begin
            best_sad <= cand_sad;
            best_d   <= cand_d;
        end
    end

    // R5 / R6: a later candidate never raises the running best score
    assert_best_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !first) |=> (best_sad <= $past(best_sad)));
endmodule

// File: rtl/sad_disparity_search.sv
module sad_disparity_search #(
    parameter int ROW_LEN  = 320,
    parameter int NUM_DISP = 30,
    parameter int WIN      = 7,
    parameter int PIX_W    = 16,
    parameter int SAD_W    = 16,
    localparam int DISP_W  = $clog2(NUM_DISP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_left,
    input  logic [PIX_W-1:0]  in_right,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DISP_W-1:0] out_disp
);
    import sad_pkg::*;

    localparam int X_W    = $clog2(ROW_LEN);
    localparam int SLOT_W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int K_W    = SLOT_W;
    localparam int HALF   = WIN / 2;
    localparam int SUM_W  = PIX_W + $clog2(WIN + 1);
    localparam int ACC_W  = ((SAD_W > SUM_W) ? SAD_W : SUM_W) + 1;

    sad_state_e state, state_nx;

    logic [X_W-1:0]    fill_col;
    logic [SLOT_W-1:0] wr_slot;
    logic [WIN-1:0]    slot_vld;
    logic [X_W-1:0]    cur_x;
    logic [DISP_W-1:0] cur_d;
    logic [K_W-1:0]    cur_k;
    logic [SAD_W-1:0]  acc;

    logic              wr_en;
    logic              fill_last;
    logic              last_k, last_d, last_x;
    logic              col_en;
    logic [X_W-1:0]    l_col, r_col;
    logic [WIN*PIX_W-1:0] l_bus, r_bus;
    logic [SUM_W-1:0]  col_sum;
    logic [ACC_W-1:0]  acc_wide;
    logic [SAD_W-1:0]  acc_sat;
    logic              upd_en;

    // ---------------- window column addressing ----------------
    always_comb begin
        int c_i;
        int rc_i;
        c_i    = int'(cur_x) - HALF + int'(cur_k);
        rc_i   = c_i - int'(cur_d);
        col_en = (c_i >= 0) && (c_i < ROW_LEN) && (rc_i >= 0);
        l_col  = col_en ? X_W'(c_i)  : '0;
        r_col  = col_en ? X_W'(rc_i) : '0;
    end

    assign wr_en     = (state == ST_FILL) && in_valid;
    assign fill_last = (fill_col == X_W'(ROW_LEN - 1));
    assign last_k    = (cur_k == K_W'(WIN - 1));
    assign last_d    = (cur_d == DISP_W'(NUM_DISP - 1)) || (int'(cur_d) == int'(cur_x));
    assign last_x    = (cur_x == X_W'(ROW_LEN - 1));

    sad_line_buffer #(.ROW_LEN(ROW_LEN), .WIN(WIN), .PIX_W(PIX_W)) u_lbuf_l (
        .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_col(fill_col),
        .wr_data(in_left), .rd_col(l_col), .rd_bus(l_bus)
    );

    sad_line_buffer #(.ROW_LEN(ROW_LEN), .WIN(WIN), .PIX_W(PIX_W)) u_lbuf_r (
        .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_col(fill_col),
        .wr_data(in_right), .rd_col(r_col), .rd_bus(r_bus)
    );

    sad_col_sum #(.WIN(WIN), .PIX_W(PIX_W)) u_col (
        .en(col_en), .row_vld(slot_vld), .l_bus(l_bus), .r_bus(r_bus), .sum(col_sum)
    );

    // ---------------- clamped accumulation ----------------
    always_comb begin
        acc_wide = ACC_W'(acc) + ACC_W'(col_sum);
        if (acc_wide > ACC_W'({SAD_W{1'b1}})) begin
            acc_sat = {SAD_W{1'b1}};
        end else begin
            acc_sat = acc_wide[SAD_W-1:0];
        end
    end

    assign upd_en = (state == ST_SEARCH) && last_k;

    sad_min_select #(.SAD_W(SAD_W), .DISP_W(DISP_W)) u_min (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .first(cur_d == '0),
        .cand_sad(acc_sat), .cand_d(cur_d), .best_d(out_disp)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FILL;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL:   if (in_valid && fill_last) state_nx = ST_SEARCH;
            ST_SEARCH: if (last_k && last_d)      state_nx = ST_EMIT;
            ST_EMIT:   if (out_ready)             state_nx = last_x ? ST_FILL : ST_SEARCH;
            default:                              state_nx = ST_FILL;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state)
            ST_FILL:   in_ready  = 1'b1;
            ST_SEARCH: ;
            ST_EMIT:   out_valid = 1'b1;
            default:   ;
        endcase
    end

    // ---------------- counters and accumulator ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_col <= '0;
            wr_slot  <= '0;
            slot_vld <= '0;
            cur_x    <= '0;
            cur_d    <= '0;
            cur_k    <= '0;
            acc      <= '0;
        end else begin
            unique case (state)
                ST_FILL: begin
                    if (in_valid) begin
                        if (fill_last) begin
                            fill_col          <= '0;
                            slot_vld[wr_slot] <= 1'b1;
                            wr_slot           <= (wr_slot == SLOT_W'(WIN - 1)) ? '0 : wr_slot + 1'b1;
                            cur_x             <= '0;
                            cur_d             <= '0;
                            cur_k             <= '0;
                            acc               <= '0;
                        end else begin
                            fill_col <= fill_col + 1'b1;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (last_k) begin
                        cur_k <= '0;
                        acc   <= '0;
                        if (!last_d) cur_d <= cur_d + 1'b1;
                    end else begin
                        cur_k <= cur_k + 1'b1;
                        acc   <= acc_sat;
                    end
                end
                ST_EMIT: begin
                    if (out_ready && !last_x) begin
                        cur_x <= cur_x + 1'b1;
                        cur_d <= '0;
                        cur_k <= '0;
                        acc   <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid));

    assert_row_end_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && fill_last) |=> !in_ready);

    assert_acc_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && !last_k) |=> (acc >= $past(acc)));

    assert_disp_le_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_disp) <= int'(cur_x)));

    assert_disp_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_disp) < NUM_DISP));

    assert_row_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && last_x) |=> (in_ready && !out_valid));

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_disp)));
endmodule

// File: tb/sim_sad_disparity_search.sv
module sim_sad_disparity_search;
    localparam int TW   = 12;
    localparam int TN   = 5;
    localparam int TWIN = 3;
    localparam int TH   = TWIN / 2;
    localparam int DW   = $clog2(TN);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [15:0]   in_left = '0;
    logic [15:0]   in_right = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_disp;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    int mL [TWIN][TW];
    int mR [TWIN][TW];
    bit mv [TWIN];
    int mslot = 0;
    int rowno = 0;

    always #10 clk = ~clk;

    sad_disparity_search #(.ROW_LEN(TW), .NUM_DISP(TN), .WIN(TWIN), .PIX_W(16), .SAD_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
        .out_ready(out_ready), .out_disp(out_disp)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    function automatic int base_l(int pat, int r, int c);
        case (pat)
            0: return ((c * 37 + r * 53 + 11) % 251) * 3;
            1: return 100;
            2: return 65535;
            default: return c * 1000 + r * 7 + 5;
        endcase
    endfunction

    function automatic int pix(int pat, int side, int r, int c);
        if (side == 0) return base_l(pat, r, c);
        case (pat)
            0: return base_l(pat, r, c + 2);
            1: return 100;
            2: return 0;
            default: return base_l(pat, r, c + 4);
        endcase
    endfunction

    // Model from R3, R4, R5, R6, R7, R10
    function automatic int model_disp(int x);
        int best = 0;
        int best_sad = 0;
        for (int d = 0; d < TN && d <= x; d++) begin
            int sad = 0;
            for (int k = 0; k < TWIN; k++) begin
                int c = x - TH + k;
                if (c >= 0 && c < TW && c - d >= 0) begin
                    int cs = 0;
                    for (int s = 0; s < TWIN; s++) begin
                        if (mv[s]) begin
                            int df = mL[s][c] - mR[s][c - d];
                            cs += (df < 0) ? -df : df;
                        end
                    end
                    sad = (sad + cs > 65535) ? 65535 : sad + cs;
                end
            end
            if (d == 0 || sad < best_sad) begin
                best = d;
                best_sad = sad;
            end
        end
        return best;
    endfunction

    task automatic do_reset();
        in_valid = 0;
        out_ready = 0;
        rst_n = 0;
        for (int s = 0; s < TWIN; s++) mv[s] = 0;
        mslot = 0;
        repeat (3) @(negedge clk);
        chk("R1 in_ready in reset", in_ready, 1);
        chk("R1 out_valid in reset", out_valid, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 in_ready after reset", in_ready, 1);
        chk("R1 out_valid after reset", out_valid, 0);
    endtask

    task automatic send_row(int pat);
        for (int c = 0; c < TW; c++) begin
            @(negedge clk);
            in_valid = 1;
            in_left  = 16'(pix(pat, 0, rowno, c));
            in_right = 16'(pix(pat, 1, rowno, c));
            mL[mslot][c] = pix(pat, 0, rowno, c);
            mR[mslot][c] = pix(pat, 1, rowno, c);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 0;
        chk("R2 in_ready low after row", in_ready, 0);
        mv[mslot] = 1;
        mslot = (mslot + 1) % TWIN;
        rowno++;
    endtask

    // Collect one row of results; exp_mode 0: model only, 1: must be 0, 2: shift-4 check
    task automatic collect_row(int exp_mode, bit stall);
        for (int x = 0; x < TW; x++) begin
            int got;
            while (!out_valid) @(negedge clk);
            got = int'(out_disp);
            chk("R2 in_ready low while emitting", in_ready, 0);
            chk("R5 disparity vs model", got, model_disp(x));
            chk("R7 disp within column", (got <= x) ? 1 : 0, 1);
            if (exp_mode == 1) chk("R6 tie resolves to 0", got, 0);
            if (exp_mode == 2 && x >= 4) chk("R3 shift match", got, 4);
            if (exp_mode == 2 && x < 4) chk("R7 true shift excluded", (got != 4) ? 1 : 0, 1);
            if (stall) begin
                repeat (2) begin
                    @(negedge clk);
                    chk("R9 valid held", out_valid, 1);
                    chk("R9 disp held", int'(out_disp), got);
                end
            end
            out_ready = 1;
            @(negedge clk);
            out_ready = 0;
        end
        chk("R8 in_ready after row", in_ready, 1);
        chk("R8 no extra result", out_valid, 0);
    endtask

    task automatic t_fill();
        // R10: first rows after reset, partially filled buffer
        send_row(0);
        collect_row(0, 0);
        send_row(0);
        collect_row(0, 0);
    endtask

    task automatic t_tie();
        // R6: identical images give equal zero scores
        for (int i = 0; i < TWIN; i++) begin
            send_row(1);
            collect_row((i == TWIN - 1) ? 1 : 0, 0);
        end
    endtask

    task automatic t_saturate();
        // R4: full-scale difference saturates every candidate, tie to 0
        for (int i = 0; i < TWIN; i++) begin
            send_row(2);
            collect_row((i == TWIN - 1) ? 1 : 0, 0);
        end
    endtask

    task automatic t_shift();
        // R3, R7, R9: shifted image with output stalls
        for (int i = 0; i < TWIN; i++) begin
            send_row(3);
            collect_row((i == TWIN - 1) ? 2 : 0, i == TWIN - 1);
        end
    endtask

    initial begin
        do_reset();
        t_fill();
        t_tie();
        t_saturate();
        t_shift();
        do_reset();
        t_fill();
        finish_run();
    end
endmodule